// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the 16-bit basic control word of a 10/100 Ethernet PHY and applies its bits directly to the media-independent interface (MII) datapath. A management agent reads and writes the word over a simple parallel bus: an address, write data, a write enable and combinational read data. The block also takes the result of the auto-negotiation engine (speed, duplex and a "negotiation started" flag). It produces the effective link speed and duplex, a one-cycle restart strobe and a power-down level for the PHY, and a loopback level.

On the datapath the block sits between the MAC-facing MII pins and the internal PHY. While isolated, it blocks every transmit input from reaching the PHY and forces every receive-side and clock output toward the MAC to zero. The management bus keeps working during isolation. A collision test bit loops the MAC's transmit enable back onto the collision output. The restart bit is sticky until the negotiation engine reports that it has started, and then clears itself.

Top module: `phy_bmcr_ctl`

## Requirements
- R1: After reset, a read of the control address returns 0x1000. Auto-negotiation enable (bit 12) is 1. Speed (bit 13), duplex (bit 8), isolate (bit 10), power down (bit 11), restart (bit 9), loopback (bit 14) and collision test (bit 7) are all 0.
- R2: Bits 6 to 0 and bit 15 always read as 0, and writes to bits 6 to 0 have no effect. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: A write to the control address with bit 15 set ignores the rest of the written word. It returns every field to its R1 value, including a pending restart, and bit 15 reads 0 from the next cycle on.
- R4: While bit 12 is 1, the effective speed output (1 = 100 Mb/s) follows the negotiated speed input, and the effective full-duplex output follows the negotiated duplex input.
- R5: While bit 12 is 0, the effective speed output equals bit 13 and the effective full-duplex output equals bit 8.
- R6: A write with bits 12 and 9 both 1 makes bit 9 read 1 from the next cycle. It keeps reading 1 until a cycle with the negotiation-started input high, after which it reads 0. A write that leaves bit 12 at 1 and clears bit 9 does not cancel it. A write that clears bit 12 does cancel it.
- R7: The restart strobe is high for exactly the one cycle after a write that sets bit 9 while restart is not pending and the written bit 12 is 1. A restart write with bit 12 at 0 produces no strobe, and bit 9 stays 0.
- R8: While bit 10 is 1, the PHY-side transmit data, enable and error outputs are 0. While bit 10 is 0, they equal the MAC-side inputs.
- R9: While bit 10 is 1, the MAC-side transmit clock, receive clock, receive data valid, receive error, receive data and carrier sense outputs are 0. While bit 10 is 0, they equal the PHY-side inputs.
- R10: While bit 7 is 1 and bit 10 is 0, the collision output is the PHY collision input OR the MAC transmit enable. With bit 7 at 0, it is the PHY collision input alone. While bit 10 is 1, it is 0.
- R11: The power-down output equals bit 11, and the loopback output equals bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_we | input | 1 | Management write enable |
| mgmt_rdata | output | 16 | Management read data (combinational) |
| an_speed | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_duplex | input | 1 | Negotiated duplex, 1 = full |
| an_started | input | 1 | Negotiation engine has started a new cycle |
| eff_speed100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| eff_full_dup | output | 1 | Effective duplex, 1 = full |
| an_restart | output | 1 | One-cycle restart strobe to the negotiation engine |
| pwr_down | output | 1 | Power-down level to the PHY blocks |
| loop_en | output | 1 | Loopback level to the PHY |
| mac_txd | input | NIB | Transmit data from MAC |
| mac_tx_en | input | 1 | Transmit enable from MAC |
| mac_tx_er | input | 1 | Transmit error from MAC |
| phy_txd | output | NIB | Gated transmit data to PHY |
| phy_tx_en | output | 1 | Gated transmit enable to PHY |
| phy_tx_er | output | 1 | Gated transmit error to PHY |
| phy_tx_clk | input | 1 | Transmit clock from PHY |
| phy_rx_clk | input | 1 | Receive clock from PHY |
| phy_rx_dv | input | 1 | Receive data valid from PHY |
| phy_rx_er | input | 1 | Receive error from PHY |
| phy_rxd | input | NIB | Receive data from PHY |
| phy_col | input | 1 | Collision from PHY |
| phy_crs | input | 1 | Carrier sense from PHY |
| mac_tx_clk | output | 1 | Gated transmit clock to MAC |
| mac_rx_clk | output | 1 | Gated receive clock to MAC |
| mac_rx_dv | output | 1 | Gated receive data valid to MAC |
| mac_rx_er | output | 1 | Gated receive error to MAC |
| mac_rxd | output | NIB | Gated receive data to MAC |
| mac_col | output | 1 | Collision to MAC, including the test loop |
| mac_crs | output | 1 | Gated carrier sense to MAC |

## Verification
The restart assertions only judge cycles with no management write, so they assume any write may legally set or release a pending restart. The stimulus mixes writes and idle cycles so that both cases occur. The assertions also take the negotiation-started flag as free to rise at any time, including while nothing is pending. The bench drives it at random to cover starts that come early, late and during writes. Clock-like MII inputs are treated as plain data sampled between edges, and the bench toggles them at random rather than as real clocks.

// File: rtl/phy_bmcr_ctl.sv
module phy_bmcr_ctl #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter int NIB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [15:0]       mgmt_wdata,
  input  logic              mgmt_we,
  output logic [15:0]       mgmt_rdata,
  input  logic              an_speed,
  input  logic              an_duplex,
  input  logic              an_started,
  output logic              eff_speed100,
  output logic              eff_full_dup,
  output logic              an_restart,
  output logic              pwr_down,
  output logic              loop_en,
  input  logic [NIB-1:0]    mac_txd,
  input  logic              mac_tx_en,
  input  logic              mac_tx_er,
  output logic [NIB-1:0]    phy_txd,
  output logic              phy_tx_en,
  output logic              phy_tx_er,
  input  logic              phy_tx_clk,
  input  logic              phy_rx_clk,
  input  logic              phy_rx_dv,
  input  logic              phy_rx_er,
  input  logic [NIB-1:0]    phy_rxd,
  input  logic              phy_col,
  input  logic              phy_crs,
  output logic              mac_tx_clk,
  output logic              mac_rx_clk,
  output logic              mac_rx_dv,
  output logic              mac_rx_er,
  output logic [NIB-1:0]    mac_rxd,
  output logic              mac_col,
  output logic              mac_crs
);
  localparam int B_SRST = 15, B_LOOP = 14, B_SPD = 13, B_ANEN = 12;
  localparam int B_PD = 11, B_ISO = 10, B_RST_AN = 9, B_DUP = 8, B_COLT = 7;

  logic loop_q, spd_q, an_en_q, pd_q, iso_q, pend_q, dup_q, colt_q, strobe_q;

  wire hit    = mgmt_addr == CTRL_ADDR;
  wire wr     = mgmt_we && hit;
  wire srst   = wr && mgmt_wdata[B_SRST];
  wire accept = wr && !mgmt_wdata[B_SRST] && mgmt_wdata[B_ANEN] && mgmt_wdata[B_RST_AN] && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0; spd_q <= 1'b0; an_en_q <= 1'b1; pd_q <= 1'b0;
      iso_q <= 1'b0; pend_q <= 1'b0; dup_q <= 1'b0; colt_q <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= accept;
      if (srst) begin
        loop_q <= 1'b0; spd_q <= 1'b0; an_en_q <= 1'b1; pd_q <= 1'b0;
        iso_q <= 1'b0; pend_q <= 1'b0; dup_q <= 1'b0; colt_q <= 1'b0;
      end else begin
        if (wr) begin
          loop_q  <= mgmt_wdata[B_LOOP];
          spd_q   <= mgmt_wdata[B_SPD];
          an_en_q <= mgmt_wdata[B_ANEN];
          pd_q    <= mgmt_wdata[B_PD];
          iso_q   <= mgmt_wdata[B_ISO];
          dup_q   <= mgmt_wdata[B_DUP];
          colt_q  <= mgmt_wdata[B_COLT];
        end
        if (accept)                         pend_q <= 1'b1;
        else if (wr && !mgmt_wdata[B_ANEN]) pend_q <= 1'b0;
        else if (an_started)                pend_q <= 1'b0;
      end
    end
  end

  assign mgmt_rdata = hit ? {1'b0, loop_q, spd_q, an_en_q, pd_q, iso_q, pend_q, dup_q, colt_q, 7'b0}
                          : 16'h0000;

  assign eff_speed100 = an_en_q ? an_speed  : spd_q;
  assign eff_full_dup = an_en_q ? an_duplex : dup_q;
  assign an_restart   = strobe_q;
  assign pwr_down     = pd_q;
  assign loop_en      = loop_q;

  assign phy_txd   = iso_q ? '0   : mac_txd;
  assign phy_tx_en = iso_q ? 1'b0 : mac_tx_en;
  assign phy_tx_er = iso_q ? 1'b0 : mac_tx_er;

  assign mac_tx_clk = !iso_q && phy_tx_clk;
  assign mac_rx_clk = !iso_q && phy_rx_clk;
  assign mac_rx_dv  = !iso_q && phy_rx_dv;
  assign mac_rx_er  = !iso_q && phy_rx_er;
  assign mac_rxd    = iso_q ? '0 : phy_rxd;
  assign mac_crs    = !iso_q && phy_crs;
  assign mac_col    = !iso_q && (phy_col || (colt_q && mac_tx_en));
endmodule

module phy_bmcr_chk #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter int NIB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [15:0]       mgmt_wdata,
  input logic              mgmt_we,
  input logic [15:0]       mgmt_rdata,
  input logic              an_started,
  input logic              an_restart,
  input logic              an_en_q,
  input logic              iso_q,
  input logic              pend_q,
  input logic              phy_tx_en,
  input logic              phy_tx_er,
  input logic [NIB-1:0]    phy_txd,
  input logic              mac_col,
  input logic              mac_crs,
  input logic              mac_rx_dv,
  input logic [NIB-1:0]    mac_rxd
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart); // R7
  AST_STROBE_WITH_AN: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> (an_en_q && pend_q)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !an_started && !mgmt_we) |=> pend_q); // R6
  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && an_started && !mgmt_we) |=> !pend_q); // R6
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_we && mgmt_addr == CTRL_ADDR && mgmt_wdata[15]) |=> (an_en_q && !iso_q && !pend_q && !an_restart)); // R3
  AST_ISO_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    iso_q |-> (!phy_tx_en && !phy_tx_er && phy_txd == '0)); // R8
  AST_ISO_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    iso_q |-> (!mac_col && !mac_crs && !mac_rx_dv && mac_rxd == '0)); // R9
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mgmt_we) |-> !mgmt_rdata[15]); // R2
endmodule

bind phy_bmcr_ctl phy_bmcr_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .NIB(NIB)) u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
  .mgmt_we(mgmt_we), .mgmt_rdata(mgmt_rdata), .an_started(an_started),
  .an_restart(an_restart), .an_en_q(an_en_q), .iso_q(iso_q), .pend_q(pend_q),
  .phy_tx_en(phy_tx_en), .phy_tx_er(phy_tx_er), .phy_txd(phy_txd),
  .mac_col(mac_col), .mac_crs(mac_crs), .mac_rx_dv(mac_rx_dv), .mac_rxd(mac_rxd)
);

// File: tb/test_phy_bmcr_ctl.sv
module test_phy_bmcr_ctl;
  localparam int AW = 5;
  localparam int NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0, mgmt_rdata;
  logic mgmt_we = 1'b0;
  logic an_speed = 1'b0, an_duplex = 1'b0, an_started = 1'b0;
  logic eff_speed100, eff_full_dup, an_restart, pwr_down, loop_en;
  logic [NB-1:0] mac_txd = '0, phy_txd, phy_rxd = '0, mac_rxd;
  logic mac_tx_en = 1'b0, mac_tx_er = 1'b0, phy_tx_en, phy_tx_er;
  logic phy_tx_clk = 1'b0, phy_rx_clk = 1'b0, phy_rx_dv = 1'b0, phy_rx_er = 1'b0;
  logic phy_col = 1'b0, phy_crs = 1'b0;
  logic mac_tx_clk, mac_rx_clk, mac_rx_dv, mac_rx_er, mac_col, mac_crs;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_bmcr_ctl #(.ADDR_W(AW), .CTRL_ADDR('0), .NIB(NB)) i_phy_bmcr_ctl (.*);

  // bench model of the control word
  bit m_loop, m_spd, m_an = 1'b1, m_pd, m_iso, m_pend, m_dup, m_colt, m_strobe;

  function automatic logic [15:0] exp_word();
    return {1'b0, m_loop, m_spd, m_an, m_pd, m_iso, m_pend, m_dup, m_colt, 7'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [15:0] er;
    bit iso;
    iso = m_iso;
    er = (mgmt_addr == '0) ? exp_word() : 16'h0;
    chk(mgmt_rdata == er, "R1/R2/R6 read data", mgmt_rdata, er);
    if (m_an) begin
      chk(eff_speed100 == an_speed && eff_full_dup == an_duplex, "R4 negotiated mode",
          {eff_speed100, eff_full_dup}, {an_speed, an_duplex});
    end else begin
      chk(eff_speed100 == m_spd && eff_full_dup == m_dup, "R5 forced mode",
          {eff_speed100, eff_full_dup}, {m_spd, m_dup});
    end
    chk(an_restart == m_strobe, "R7 restart strobe", an_restart, m_strobe);
    chk(pwr_down == m_pd && loop_en == m_loop, "R11 power down / loopback",
        {pwr_down, loop_en}, {m_pd, m_loop});
    chk({phy_txd, phy_tx_en, phy_tx_er} == (iso ? 6'b0 : {mac_txd, mac_tx_en, mac_tx_er}),
        "R8 transmit gating", {phy_txd, phy_tx_en, phy_tx_er},
        iso ? 6'b0 : {mac_txd, mac_tx_en, mac_tx_er});
    chk({mac_tx_clk, mac_rx_clk, mac_rx_dv, mac_rx_er, mac_rxd, mac_crs} ==
        (iso ? 9'b0 : {phy_tx_clk, phy_rx_clk, phy_rx_dv, phy_rx_er, phy_rxd, phy_crs}),
        "R9 receive gating", {mac_tx_clk, mac_rx_clk, mac_rx_dv, mac_rx_er, mac_rxd, mac_crs},
        iso ? 9'b0 : {phy_tx_clk, phy_rx_clk, phy_rx_dv, phy_rx_er, phy_rxd, phy_crs});
    chk(mac_col == (!iso && (phy_col || (m_colt && mac_tx_en))), "R10 collision",
        mac_col, !iso && (phy_col || (m_colt && mac_tx_en)));
  endtask

  task automatic model_edge();
    bit wr, acc;
    wr  = mgmt_we && mgmt_addr == '0;
    acc = wr && !mgmt_wdata[15] && mgmt_wdata[12] && mgmt_wdata[9] && !m_pend;
    m_strobe = acc;
    if (wr && mgmt_wdata[15]) begin
      {m_loop, m_spd, m_an, m_pd, m_iso, m_pend, m_dup, m_colt} = 8'b0010_0000;
    end else begin
      if (wr) begin
        m_loop = mgmt_wdata[14]; m_spd = mgmt_wdata[13]; m_an = mgmt_wdata[12];
        m_pd = mgmt_wdata[11]; m_iso = mgmt_wdata[10]; m_dup = mgmt_wdata[8];
        m_colt = mgmt_wdata[7];
      end
      if (acc) m_pend = 1'b1;
      else if (wr && !mgmt_wdata[12]) m_pend = 1'b0;
      else if (an_started) m_pend = 1'b0;
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input bit we, input logic [15:0] wd, input bit st);
    @(negedge clk);
    mgmt_addr = a; mgmt_we = we; mgmt_wdata = wd; an_started = st;
    {an_speed, an_duplex} = 2'($urandom);
    {mac_txd, mac_tx_en, mac_tx_er} = 6'($urandom);
    {phy_tx_clk, phy_rx_clk, phy_rx_dv, phy_rx_er, phy_rxd, phy_col, phy_crs} = 10'($urandom);
    #1;
    check_outputs();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(mgmt_rdata == 16'h1000, "R1 reset word", mgmt_rdata, 16'h1000);
    // R2: other address and reserved bits
    step(5'd3, 1'b0, 16'h0, 1'b0);
    step(5'd3, 1'b1, 16'h2400, 1'b0);
    step(5'd0, 1'b1, 16'h007F, 1'b0);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    chk(mgmt_rdata == 16'h0000, "R2 reserved bits ignore writes", mgmt_rdata, 16'h0000);
    // R3: soft reset with all bits set
    step(5'd0, 1'b1, 16'h6D80, 1'b0);
    step(5'd0, 1'b1, 16'hFFFF, 1'b0);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    chk(mgmt_rdata == 16'h1000, "R3 soft reset readback", mgmt_rdata, 16'h1000);
    // R6/R7: restart pending, write of 0 does not cancel, start clears
    step(5'd0, 1'b1, 16'h1200, 1'b0);
    step(5'd0, 1'b1, 16'h1000, 1'b0);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    chk(mgmt_rdata[9] == 1'b1, "R6 restart still pending", mgmt_rdata[9], 1);
    step(5'd0, 1'b0, 16'h0, 1'b1);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    chk(mgmt_rdata[9] == 1'b0, "R6 restart released", mgmt_rdata[9], 0);
    // R7: restart with negotiation disabled
    step(5'd0, 1'b1, 16'h0200, 1'b0);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    chk(an_restart == 1'b0 && mgmt_rdata[9] == 1'b0, "R7 no restart when disabled",
        {an_restart, mgmt_rdata[9]}, 0);
    // R5/R10/R8/R9: forced mode, collision test, then isolate on top
    step(5'd0, 1'b1, 16'h2180, 1'b0);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    step(5'd0, 1'b1, 16'h2580, 1'b0);
    step(5'd0, 1'b0, 16'h0, 1'b0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      bit we;
      logic [AW-1:0] a;
      w  = 16'($urandom);
      if (($urandom % 16) != 0) w[15] = 1'b0;
      if (($urandom % 4) != 0) w[12] = 1'b1;
      we = ($urandom % 3) == 0;
      a  = (($urandom % 8) == 0) ? AW'($urandom) : '0;
      step(a, we, w, ($urandom % 6) == 0);
    end
    step(5'd0, 1'b0, 16'h0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule